// File: doc/BRIEF.md
# Composite-Field Byte Substitution Unit

This block performs the AES byte substitution in either direction on one byte per cycle. A single mode bit picks the forward substitution or its inverse. Both directions share one multiplicative inverter over GF(2^8). The inverter is built from logic: the byte is mapped by a linear isomorphism into the tower field GF((2^4)^2) and inverted there using GF(2^4) arithmetic. The result is then mapped back. The forward affine step sits after the inverter, and the inverse affine step sits before it, so only those two small XOR networks are specific to a direction.

The parameter `STAGES` (0 to 3) places register slices at fixed cut points: at the output, after the entry mapping, and after the GF(2^4) inversion. A valid bit and the mode bit travel with each byte through these slices. Each cut raises the reachable clock rate and adds one cycle of latency. With `STAGES = 0` the unit is purely combinational.

Top module: `cf_sbox`

## Requirements
- R1: With `inv_mode_i = 0` (forward), `byte_o` equals the affine map of the GF(2^8) inverse of `byte_i`, where the inverse uses the polynomial x^8+x^4+x^3+x+1, the inverse of 0x00 is taken as 0x00, and the affine map is b = a ^ rotl(a,1) ^ rotl(a,2) ^ rotl(a,3) ^ rotl(a,4) ^ 0x63. Examples: 0x01 gives 0x7C and 0x53 gives 0xED.
- R2: Zero is handled without special casing: forward 0x00 gives 0x63, and inverse 0x63 gives 0x00.
- R3: With `inv_mode_i = 1` (inverse), `byte_o` equals the GF(2^8) inverse of rotl(a,1) ^ rotl(a,3) ^ rotl(a,6) ^ 0x05. This means that for every x, inverse(forward(x)) = x over all 256 values.
- R4: Feeding a forward result back through the unit in inverse mode returns the original byte for every one of the 256 inputs.
- R5: For `STAGES` of 1 or more, `out_valid_o` is asserted exactly `STAGES` clock cycles after the `in_valid_i` cycle that carried the byte. `byte_o` holds that byte's result in the same cycle.
- R6: The mode is taken per byte. When the mode alternates every cycle in a back-to-back stream, each result follows the mode that was sampled with its own byte.
- R7: While `rst_ni` is low, and after release until a valid byte arrives, `out_valid_o` is 0.
- R8: With `STAGES = 0`, `out_valid_o` equals `in_valid_i`, and `byte_o` is the substitution of the present `byte_i` in the same cycle.
- R9: Idle input cycles produce idle output cycles at the same spacing. No result is dropped or repeated, and during an idle slot the output data register keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte on `byte_i` is to be processed |
| inv_mode_i | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| byte_i | input | 8 | Input byte |
| out_valid_o | output | 1 | `byte_o` carries a result |
| byte_o | output | 8 | Substituted byte |

## Verification
The bench builds two instances side by side. The first uses `STAGES = 3`, so every cut point is registered. With it, the exact three-cycle latency, the per-byte mode carried through every slice, and gap preservation under an irregular valid pattern can all be observed. The second uses `STAGES = 0`, which exposes the bare combinational path. This allows same-cycle checks and a forward-then-inverse round trip on all 256 values using the unit's own outputs. Both instances are compared against tables that the bench builds by brute-force GF(2^8) inversion.

// File: rtl/cf_sbox_pkg.sv
package cf_sbox_pkg;

    // Column k of a matrix is the image of input bit k.
    typedef logic [7:0][7:0] bmat_t;

    // Constant term of y^2 + y + NU over GF(2^4) (poly x^4+x+1); trace 1 keeps it irreducible.
    localparam logic [3:0] NU = 4'hC;

    typedef struct packed {
        logic       inv;
        logic [3:0] hi;
        logic [3:0] lo;
    } cf_word_t;

    typedef struct packed {
        logic       inv;
        logic [3:0] hi;
        logic [3:0] lo;
        logic [3:0] dinv;
    } cf_norm_t;

    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] acc;
        logic [3:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) acc ^= sh;
            sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'h3 : 4'h0);
        end
        return acc;
    endfunction

    // a^14 = a^-1 for nonzero a; zero maps to zero.
    function automatic logic [3:0] gf16_inv(input logic [3:0] a);
        logic [3:0] p2, p4, p8;
        p2 = gf16_mul(a, a);
        p4 = gf16_mul(p2, p2);
        p8 = gf16_mul(p4, p4);
        return gf16_mul(gf16_mul(p8, p4), p2);
    endfunction

    function automatic logic [7:0] gf256_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] mat_apply(input bmat_t m, input logic [7:0] v);
        logic [7:0] r;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            r ^= v[k] ? m[k] : 8'h00;
        end
        return r;
    endfunction

    // Composite {hi,lo} -> binary: x^k maps to g^k, x^k*y maps to g^k*Y,
    // where g is a root of x^4+x+1 and Y a root of y^2+y+NU(g) in GF(2^8).
    function automatic bmat_t build_to_bin();
        logic [7:0] g, yr, lam, gp, c, p2, p4;
        logic       g_ok, y_ok;
        bmat_t      m;
        g = 8'h00; yr = 8'h00; g_ok = 1'b0; y_ok = 1'b0; m = '0;
        for (int v = 2; v < 256; v++) begin
            c  = 8'(v);
            p2 = gf256_mul(c, c);
            p4 = gf256_mul(p2, p2);
            if (!g_ok && ((p4 ^ c ^ 8'h01) == 8'h00)) begin
                g    = c;
                g_ok = 1'b1;
            end
        end
        lam = 8'h00;
        gp  = 8'h01;
        for (int k = 0; k < 4; k++) begin
            if (NU[k]) lam ^= gp;
            gp = gf256_mul(gp, g);
        end
        for (int v = 2; v < 256; v++) begin
            c = 8'(v);
            if (!y_ok && ((gf256_mul(c, c) ^ c ^ lam) == 8'h00)) begin
                yr   = c;
                y_ok = 1'b1;
            end
        end
        gp = 8'h01;
        for (int k = 0; k < 4; k++) begin
            m[k]     = gp;
            m[k + 4] = gf256_mul(gp, yr);
            gp       = gf256_mul(gp, g);
        end
        return m;
    endfunction

    // Inverse map: for each binary unit vector, the composite word that produces it.
    function automatic bmat_t build_to_cf(input bmat_t fwd);
        bmat_t      m;
        logic [7:0] c, img;
        m = '0;
        for (int v = 1; v < 256; v++) begin
            c   = 8'(v);
            img = mat_apply(fwd, c);
            if ((img != 8'h00) && ((img & (img - 8'h01)) == 8'h00)) begin
                for (int j = 0; j < 8; j++) begin
                    if (img[j]) m[j] = c;
                end
            end
        end
        return m;
    endfunction

    localparam bmat_t TO_BIN = build_to_bin();
    localparam bmat_t TO_CF  = build_to_cf(TO_BIN);

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    function automatic logic [7:0] aff_fwd(input logic [7:0] a);
        return a ^ rotl8(a, 1) ^ rotl8(a, 2) ^ rotl8(a, 3) ^ rotl8(a, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] aff_inv(input logic [7:0] a);
        return rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
    endfunction

endpackage

// File: rtl/sbox_front.sv
module sbox_front
    import cf_sbox_pkg::*;
(
    input  logic       inv_mode_i,
    input  logic [7:0] byte_i,
    output cf_word_t   word_o
);
    logic [7:0] sel_d;
    logic [7:0] cf_d;
    cf_word_t   word_d;

    always_comb begin
        sel_d       = inv_mode_i ? aff_inv(byte_i) : byte_i;
        cf_d        = mat_apply(TO_CF, sel_d);
        word_d.inv  = inv_mode_i;
        word_d.hi   = cf_d[7:4];
        word_d.lo   = cf_d[3:0];
    end

    assign word_o = word_d;

    always_comb begin
        if (!$isunknown(sel_d)) begin
            // R1
            iso_zero_chk: assert ((sel_d == 8'h00) == ((word_d.hi == 4'h0) && (word_d.lo == 4'h0)));
        end
    end

endmodule

// File: rtl/sbox_norm_inv.sv
module sbox_norm_inv
    import cf_sbox_pkg::*;
(
    input  cf_word_t word_i,
    output cf_norm_t norm_o
);
    logic [3:0] d_d;
    cf_norm_t   norm_d;

    always_comb begin
        d_d = gf16_mul(NU, gf16_mul(word_i.hi, word_i.hi))
            ^ gf16_mul(word_i.hi, word_i.lo)
            ^ gf16_mul(word_i.lo, word_i.lo);
        norm_d.inv  = word_i.inv;
        norm_d.hi   = word_i.hi;
        norm_d.lo   = word_i.lo;
        norm_d.dinv = gf16_inv(d_d);
    end

    assign norm_o = norm_d;

    always_comb begin
        if (!$isunknown(word_i)) begin
            // R1
            norm_nz_chk: assert (((word_i.hi | word_i.lo) != 4'h0) == (d_d != 4'h0));
            // R3
            dinv_chk: assert ((d_d == 4'h0) || (gf16_mul(d_d, norm_d.dinv) == 4'h1));
        end
    end

endmodule

// File: rtl/sbox_back.sv
module sbox_back
    import cf_sbox_pkg::*;
(
    input  cf_norm_t   norm_i,
    output logic [7:0] byte_o
);
    logic [3:0] hi_d;
    logic [3:0] lo_d;
    logic [7:0] bin_d;
    logic [7:0] byte_d;

    always_comb begin
        hi_d   = gf16_mul(norm_i.hi, norm_i.dinv);
        lo_d   = gf16_mul(norm_i.hi ^ norm_i.lo, norm_i.dinv);
        bin_d  = mat_apply(TO_BIN, {hi_d, lo_d});
        byte_d = norm_i.inv ? bin_d : aff_fwd(bin_d);
    end

    assign byte_o = byte_d;

endmodule

// File: rtl/sbox_pipe_reg.sv
module sbox_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         vld_i,
    input  logic [W-1:0] data_i,
    output logic         vld_o,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d      = slot_q;
        slot_d.vld  = vld_i;
        if (vld_i) slot_d.data = data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q <= '0;
        else         slot_q <= slot_d;
    end

    assign vld_o  = slot_q.vld;
    assign data_o = slot_q.data;

    // R5
    vld_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) vld_i |=> vld_o);
    // R9
    vld_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !vld_i |=> !vld_o);
    // R9
    gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !vld_i |=> $stable(data_o));

endmodule

// File: rtl/cf_sbox.sv
module cf_sbox
    import cf_sbox_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       in_valid_i,
    input  logic       inv_mode_i,
    input  logic [7:0] byte_i,
    output logic       out_valid_o,
    output logic [7:0] byte_o
);
    localparam bit CUT_OUT = (STAGES >= 1);
    localparam bit CUT_A   = (STAGES >= 2);
    localparam bit CUT_B   = (STAGES >= 3);
    localparam int WA      = $bits(cf_word_t);
    localparam int WB      = $bits(cf_norm_t);

    if (STAGES < 0 || STAGES > 3) begin : g_bad_stages
        $error("cf_sbox: STAGES must be 0..3");
    end

    cf_word_t   a_d, a_q;
    cf_norm_t   b_d, b_q;
    logic [7:0] o_d;
    logic       a_vld, b_vld;

    sbox_front u_front (
        .inv_mode_i (inv_mode_i),
        .byte_i     (byte_i),
        .word_o     (a_d)
    );

    if (CUT_A) begin : g_cut_a
        sbox_pipe_reg #(.W(WA)) u_reg (
            .clk_i (clk_i), .rst_ni (rst_ni),
            .vld_i (in_valid_i), .data_i (a_d),
            .vld_o (a_vld), .data_o (a_q)
        );
    end else begin : g_thru_a
        assign a_vld = in_valid_i;
        assign a_q   = a_d;
    end

    sbox_norm_inv u_norm (
        .word_i (a_q),
        .norm_o (b_d)
    );

    if (CUT_B) begin : g_cut_b
        sbox_pipe_reg #(.W(WB)) u_reg (
            .clk_i (clk_i), .rst_ni (rst_ni),
            .vld_i (a_vld), .data_i (b_d),
            .vld_o (b_vld), .data_o (b_q)
        );
    end else begin : g_thru_b
        assign b_vld = a_vld;
        assign b_q   = b_d;
    end

    sbox_back u_back (
        .norm_i (b_q),
        .byte_o (o_d)
    );

    if (CUT_OUT) begin : g_cut_out
        sbox_pipe_reg #(.W(8)) u_reg (
            .clk_i (clk_i), .rst_ni (rst_ni),
            .vld_i (b_vld), .data_i (o_d),
            .vld_o (out_valid_o), .data_o (byte_o)
        );
    end else begin : g_thru_out
        assign out_valid_o = b_vld;
        assign byte_o      = o_d;
    end

endmodule

// File: tb/cf_sbox_tb.sv
module cf_sbox_tb;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vin = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] din = 8'h00;
    logic       vout, vout0;
    logic [7:0] dout, dout0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] fwd_tab [256];
    logic [7:0] inv_tab [256];

    logic [7:0] exp_q [$];
    int         cyc_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cf_sbox #(.STAGES(LAT)) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .in_valid_i (vin), .inv_mode_i (mode),
        .byte_i (din), .out_valid_o (vout), .byte_o (dout)
    );

    cf_sbox #(.STAGES(0)) u_dut_s0 (
        .clk_i (clk), .rst_ni (rst_n), .in_valid_i (vin), .inv_mode_i (mode),
        .byte_i (din), .out_valid_o (vout0), .byte_o (dout0)
    );

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p ^= (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p ^= (16'h011B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] ref_inv(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        for (int b = 1; b < 256; b++) if (ref_mul(a, 8'(b)) == 8'h01) r = 8'(b);
        return r;
    endfunction

    function automatic logic [7:0] ref_aff(input logic [7:0] a);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8];
        return r ^ 8'h63;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: applies one slot, queues the pipelined expectation, checks the STAGES=0 copy.
    task automatic send(input logic v, input logic m, input logic [7:0] b,
                        input logic [7:0] exp, input string tag);
        @(negedge clk);
        vin = v; mode = m; din = b;
        if (v) begin
            exp_q.push_back(exp);
            cyc_q.push_back(cyc);
            tag_q.push_back(tag);
        end
        #5;
        check_int("R8 valid", int'(vout0), int'(v));
        if (v) check8({"R8 ", tag}, dout0, exp);
    endtask

    // Monitor / scoreboard for the pipelined instance.
    always @(posedge clk) begin
        #5;
        if (rst_n && vout) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 unexpected output actual=%02h expected=none", dout);
            end else begin
                logic [7:0] e;
                int         c;
                string      t;
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                check8(t, dout, e);
                check_int("R5 latency", cyc - c, LAT);
            end
        end
    end

    initial begin
        #(20 * 60000);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        logic [7:0] y;
        for (int x = 0; x < 256; x++) fwd_tab[x] = ref_aff(ref_inv(8'(x)));
        for (int x = 0; x < 256; x++) inv_tab[fwd_tab[x]] = 8'(x);

        // R7: reset state
        repeat (3) @(negedge clk);
        check_int("R7 in reset", int'(vout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        check_int("R7 after release", int'(vout), 0);

        // R2 / R1 / R3 known values
        send(1'b1, 1'b0, 8'h00, 8'h63, "R2 fwd 00");
        send(1'b1, 1'b0, 8'h01, 8'h7C, "R1 fwd 01");
        send(1'b1, 1'b0, 8'h53, 8'hED, "R1 fwd 53");
        send(1'b1, 1'b1, 8'h63, 8'h00, "R2 inv 63");
        send(1'b1, 1'b1, 8'hED, 8'h53, "R3 inv ED");

        // R1: full forward sweep
        for (int x = 0; x < 256; x++) send(1'b1, 1'b0, 8'(x), fwd_tab[x], "R1 fwd sweep");
        // R3: full inverse sweep
        for (int x = 0; x < 256; x++) send(1'b1, 1'b1, 8'(x), inv_tab[x], "R3 inv sweep");
        // R6: mode alternates every byte
        for (int x = 0; x < 256; x++)
            send(1'b1, x[0], 8'(255 - x), x[0] ? inv_tab[255 - x] : fwd_tab[255 - x], "R6 alt mode");

        // R9: irregular gaps, idle slots carry junk data
        lfsr = 8'hA5;
        for (int i = 0; i < 200; i++) begin
            logic v;
            v = lfsr[0] ^ lfsr[5];
            send(v, lfsr[2], lfsr, lfsr[2] ? inv_tab[lfsr] : fwd_tab[lfsr], "R9 gaps");
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end

        repeat (LAT + 2) send(1'b0, 1'b0, 8'h00, 8'h00, "drain");
        check_int("R9 all results delivered", exp_q.size(), 0);

        // R4: round trip through the combinational instance using its own outputs
        for (int x = 0; x < 256; x++) begin
            @(negedge clk);
            vin = 1'b0; mode = 1'b0; din = 8'(x);
            #5;
            y = dout0;
            @(negedge clk);
            mode = 1'b1; din = y;
            #5;
            check8("R4 round trip", dout0, 8'(x));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule